// File: doc/BRIEF.md
# Quadrature Position Counter with Byte-Wide Command Port

The block counts the position of an incremental encoder from its two phase signals, A and B. Both pins are synchronised, sampled at a programmable rate and decoded four times per input cycle into up and down steps on a 24-bit counter that wraps. A host controls the block through a byte-wide port that has two addresses. A control address takes command bytes. A data address gives access to a multi-byte preset register and a multi-byte output latch.

Software does not read the live counter. It first resets the byte pointer and issues a snapshot command, which freezes the count in the output latch. Three data reads then return that snapshot, lowest byte first, while the counter goes on counting. Data writes fill the preset register the same way. Further commands move the preset into the counter or into the sample-rate prescaler, clear the counter, and clear the error flag. The error flag records a sample in which both phases changed at once. Counting stays off until the host has both enabled the inputs and selected x4 decoding.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the read data output is 0x00, the error flag is low, and a snapshot of the counter reads back as zero.
- R2: The counter does not move until both the input-enable command (0x41) and the x4-mode command (0x38) have been written to the control address. Encoder motion before that point is not counted, and neither command alone enables counting.
- R3: Once enabled, every legal phase change moves the count by exactly one. The phase sequence {A,B} = 00, 10, 11, 01, 00 (A leading B) counts up, and the reverse sequence counts down, which gives four counts per input cycle.
- R4: The count wraps modulo 2^24. One step down from zero gives 0xFFFFFF, and one step up from 0xFFFFFF gives zero.
- R5: Command 0x10 copies the counter into the output latch. Later data reads return that frozen value while the counter keeps running. A snapshot that falls in the same cycle as a step captures the value from before the step.
- R6: Every data read returns the latch byte at the byte pointer: position 0 holds bits 7:0, position 1 holds bits 15:8 and position 2 holds bits 23:16. The byte appears on the read data output in the cycle after the read strobe. Each read moves the pointer on by one, and the pointer wraps from position 2 back to 0.
- R7: Command 0x01 returns the byte pointer to position 0.
- R8: Command 0x02 clears the counter to zero, and it overrides a count step in the same cycle.
- R9: Each data write stores its byte into the preset register at the byte pointer and moves the pointer on, with the same wrap as reads. Command 0x08 loads the preset into the counter, and it overrides a count step in the same cycle.
- R10: Command 0x18 loads preset bits 7:0 into the prescaler and restarts its divider. With a prescaler value of N, the decoder samples the inputs once every N+1 clocks, with the first sample N+1 clocks after the command. Two phase changes that fall between two samples appear as one illegal change.
- R11: A sample in which both A and B changed sets the error flag and leaves the count unchanged. Command 0x06 clears the flag.
- R12: Each input passes through two flip-flops. With a prescaler value of 0, a pin change made before rising edge k shows in the counter after edge k+2 and not earlier.
- R13: Command bytes that are not listed above change neither the counter nor the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe; ignored when host_wr is also high |
| host_ctrl | input | 1 | Address select: 1 = control (commands), 0 = data |
| host_wdata | input | 8 | Write byte: a command code or a preset byte |
| host_rdata | output | 8 | Latch byte, registered, valid in the cycle after a data read |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| err_flag | output | 1 | Sticky flag for an illegal phase change |

## Verification
A host command and a decoded count step can land on the same clock edge. This covers a clear against a step, a preset load against a step, and a snapshot against a step. The bench gets these collisions by changing an encoder pin at a known falling edge and then timing the command strobe so that it is active across the third rising edge, which is the edge on which the synchronised step reaches the counter. The result is judged through a later snapshot. A clear or a load must win outright. A colliding snapshot must hold the count from before the step, and the step must still appear in the next snapshot.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    // Host port byte width and command codes (control address)
    localparam int HOST_W = 8;

    localparam logic [HOST_W-1:0] CMD_PTR_RST   = 8'h01;
    localparam logic [HOST_W-1:0] CMD_CNT_CLR   = 8'h02;
    localparam logic [HOST_W-1:0] CMD_ERR_CLR   = 8'h06;
    localparam logic [HOST_W-1:0] CMD_PRESET_LD = 8'h08;
    localparam logic [HOST_W-1:0] CMD_SNAP      = 8'h10;
    localparam logic [HOST_W-1:0] CMD_PSC_LD    = 8'h18;
    localparam logic [HOST_W-1:0] CMD_X4_SEL    = 8'h38;
    localparam logic [HOST_W-1:0] CMD_AB_EN     = 8'h41;

    // One-cycle command pulses decoded from a control write
    typedef struct packed {
        logic ptr_rst;
        logic cnt_clr;
        logic err_clr;
        logic preset_ld;
        logic snap;
        logic psc_ld;
        logic x4_sel;
        logic ab_en;
    } qpc_cmd_t;

    typedef enum logic [1:0] {
        QS_HOLD,
        QS_UP,
        QS_DOWN,
        QS_BAD
    } qstep_e;

    // Position of a phase pair {A,B} on the cycle 00 -> 10 -> 11 -> 01
    function automatic logic [1:0] phase_idx(input logic [1:0] ab);
        return {ab[0], ab[1] ^ ab[0]};
    endfunction

    function automatic qstep_e classify(input logic [1:0] prev_ab,
                                        input logic [1:0] cur_ab);
        logic [1:0] delta;
        delta = phase_idx(cur_ab) - phase_idx(prev_ab);
        case (delta)
            2'd1:    return QS_UP;
            2'd3:    return QS_DOWN;
            2'd2:    return QS_BAD;
            default: return QS_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/qpc_in_sync.sv
module qpc_in_sync #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       pins,
    input  logic [PSC_W-1:0] psc,
    input  logic             restart,
    output logic [1:0]       ab_s,
    output logic             tick
);

    logic [1:0]       meta_q;
    logic [1:0]       sync_q;
    logic [PSC_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pins;
            sync_q <= meta_q;
        end
    end

    assign tick = (div_q == psc);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign ab_s = sync_q;

endmodule

// File: rtl/qpc_quad_step.sv
module qpc_quad_step
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ab_s,
    input  logic       tick,
    input  logic       run_en,
    output logic       q_up,
    output logic       q_dn,
    output logic       q_bad
);

    logic [1:0] prev_q;
    qstep_e     kind;

    always_comb kind = classify(prev_q, ab_s);

    // The previous sample follows the pins even while counting is off,
    // so enabling never produces a spurious step.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (tick) begin
            prev_q <= ab_s;
        end
    end

    assign q_up  = tick && run_en && (kind == QS_UP);
    assign q_dn  = tick && run_en && (kind == QS_DOWN);
    assign q_bad = tick && run_en && (kind == QS_BAD);

endmodule

// File: rtl/qpc_host_port.sv
module qpc_host_port
    import qpc_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_ctrl,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic [CNT_W-1:0]  latch_val,
    output qpc_cmd_t          cmd,
    output logic [CNT_W-1:0]  preset_val,
    output logic [PSC_W-1:0]  psc_val,
    output logic              run_en,
    output logic [HOST_W-1:0] host_rdata
);

    localparam int NBYTES = (CNT_W + HOST_W - 1) / HOST_W;
    localparam int PAD_W  = NBYTES * HOST_W;
    localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic              ctl_wr;
    logic              dat_wr;
    logic              dat_rd;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_nxt;
    logic [PAD_W-1:0]  preset_q;
    logic [PAD_W-1:0]  latch_pad;
    logic [HOST_W-1:0] rd_byte;
    logic              ab_en_q;
    logic              x4_q;
    logic [PSC_W-1:0]  psc_q;
    logic [HOST_W-1:0] rdata_q;

    assign ctl_wr = host_wr && host_ctrl;
    assign dat_wr = host_wr && !host_ctrl;
    assign dat_rd = host_rd && !host_ctrl && !host_wr;

    always_comb begin
        cmd           = '0;
        cmd.ptr_rst   = ctl_wr && (host_wdata == CMD_PTR_RST);
        cmd.cnt_clr   = ctl_wr && (host_wdata == CMD_CNT_CLR);
        cmd.err_clr   = ctl_wr && (host_wdata == CMD_ERR_CLR);
        cmd.preset_ld = ctl_wr && (host_wdata == CMD_PRESET_LD);
        cmd.snap      = ctl_wr && (host_wdata == CMD_SNAP);
        cmd.psc_ld    = ctl_wr && (host_wdata == CMD_PSC_LD);
        cmd.x4_sel    = ctl_wr && (host_wdata == CMD_X4_SEL);
        cmd.ab_en     = ctl_wr && (host_wdata == CMD_AB_EN);
    end

    assign ptr_nxt   = (ptr_q >= PTR_W'(NBYTES - 1)) ? '0 : ptr_q + 1'b1;
    assign latch_pad = PAD_W'(latch_val);

    always_comb begin
        rd_byte = latch_pad[HOST_W-1:0];
        for (int i = 0; i < NBYTES; i++) begin
            if (ptr_q == PTR_W'(i)) begin
                rd_byte = latch_pad[i*HOST_W +: HOST_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            preset_q <= '0;
            rdata_q  <= '0;
        end else if (cmd.ptr_rst) begin
            ptr_q <= '0;
        end else if (dat_wr) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (ptr_q == PTR_W'(i)) begin
                    preset_q[i*HOST_W +: HOST_W] <= host_wdata;
                end
            end
            ptr_q <= ptr_nxt;
        end else if (dat_rd) begin
            rdata_q <= rd_byte;
            ptr_q   <= ptr_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ab_en_q <= 1'b0;
            x4_q    <= 1'b0;
            psc_q   <= '0;
        end else begin
            if (cmd.ab_en)  ab_en_q <= 1'b1;
            if (cmd.x4_sel) x4_q    <= 1'b1;
            if (cmd.psc_ld) psc_q   <= preset_q[PSC_W-1:0];
        end
    end

    assign preset_val = preset_q[CNT_W-1:0];
    assign psc_val    = psc_q;
    assign run_en     = ab_en_q && x4_q;
    assign host_rdata = rdata_q;

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_ctrl,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       enc_a,
    input  logic       enc_b,
    output logic       err_flag
);

    qpc_cmd_t         cmd;
    logic [CNT_W-1:0] preset_v;
    logic [PSC_W-1:0] psc_v;
    logic             run_en;
    logic [1:0]       ab_s;
    logic             tick;
    logic             q_up;
    logic             q_dn;
    logic             q_bad;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] latch_q;
    logic             err_q;

    qpc_host_port #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_port (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_ctrl  (host_ctrl),
        .host_wdata (host_wdata),
        .latch_val  (latch_q),
        .cmd        (cmd),
        .preset_val (preset_v),
        .psc_val    (psc_v),
        .run_en     (run_en),
        .host_rdata (host_rdata)
    );

    qpc_in_sync #(.PSC_W(PSC_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pins    ({enc_a, enc_b}),
        .psc     (psc_v),
        .restart (cmd.psc_ld),
        .ab_s    (ab_s),
        .tick    (tick)
    );

    qpc_quad_step u_step (
        .clk    (clk),
        .rst    (rst),
        .ab_s   (ab_s),
        .tick   (tick),
        .run_en (run_en),
        .q_up   (q_up),
        .q_dn   (q_dn),
        .q_bad  (q_bad)
    );

    // Host commands take priority over decoded steps; a snapshot sees
    // the register value from before this edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            latch_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (cmd.cnt_clr) begin
                count_q <= '0;
            end else if (cmd.preset_ld) begin
                count_q <= preset_v;
            end else if (q_up) begin
                count_q <= count_q + CNT_W'(1);
            end else if (q_dn) begin
                count_q <= count_q - CNT_W'(1);
            end

            if (cmd.snap) latch_q <= count_q;

            if (q_bad) begin
                err_q <= 1'b1;
            end else if (cmd.err_clr) begin
                err_q <= 1'b0;
            end
        end
    end

    assign err_flag = err_q;

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker
    import qpc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input qpc_cmd_t         cmd,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] latch_q,
    input logic [CNT_W-1:0] preset_v,
    input logic             run_en,
    input logic             q_bad,
    input logic             err_flag
);

    // R2: no movement while counting is disabled, unless a clear or load
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(run_en) && !$past(cmd.cnt_clr) && !$past(cmd.preset_ld))
            |-> $stable(count_q));

    // R3, R4: free counting moves by at most one, modulo 2^CNT_W
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmd.cnt_clr) && !$past(cmd.preset_ld))
            |-> (count_q == $past(count_q)
                 || count_q == CNT_W'($past(count_q) + 1'b1)
                 || count_q == CNT_W'($past(count_q) - 1'b1)));

    // R8: a clear always wins
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $past(cmd.cnt_clr) |-> (count_q == '0));

    // R9: a preset load wins over a step
    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd.preset_ld) && !$past(cmd.cnt_clr))
            |-> (count_q == $past(preset_v)));

    // R5: snapshot holds the pre-edge count
    p_snap_r5: assert property (@(posedge clk) disable iff (rst)
        $past(cmd.snap) |-> (latch_q == $past(count_q)));

    // R11: an illegal sample raises the flag and does not count
    p_bad_r11: assert property (@(posedge clk) disable iff (rst)
        $past(q_bad) |-> err_flag);

    p_errclr_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd.err_clr) && !$past(q_bad)) |-> !err_flag);

endmodule

bind quad_pos_counter qpc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .count_q  (count_q),
    .latch_q  (latch_q),
    .preset_v (preset_v),
    .run_en   (run_en),
    .q_bad    (q_bad),
    .err_flag (err_flag)
);

// File: tb/quad_pos_counter_test.sv
module quad_pos_counter_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_ctrl = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       enc_a = 1'b0;
    logic       enc_b = 1'b0;
    logic       err_flag;

    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;
    bit         en_model = 1'b0;
    logic [23:0] exp_cnt = '0;

    quad_pos_counter uut (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_ctrl  (host_ctrl),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .enc_a      (enc_a),
        .enc_b      (enc_b),
        .err_flag   (err_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Phase position per R3: 00 -> 10 -> 11 -> 01 counts up
    function automatic logic [1:0] pos_of(input logic a, input logic b);
        case ({a, b})
            2'b00:   return 2'd0;
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [1:0] pins_of(input logic [1:0] p);
        case (p)
            2'd0:    return 2'b00;
            2'd1:    return 2'b10;
            2'd2:    return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        host_ctrl = 1'b1; host_wr = 1'b1; host_wdata = c;
        @(negedge clk);
        host_wr = 1'b0; host_ctrl = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] d);
        @(negedge clk);
        host_ctrl = 1'b0; host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] v);
        @(negedge clk);
        host_ctrl = 1'b0; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic read_held(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        send_cmd(8'h01);
        get_byte(b0); get_byte(b1); get_byte(b2);
        v = {b2, b1, b0};
    endtask

    task automatic fetch(output logic [23:0] v);
        send_cmd(8'h10);
        read_held(v);
    endtask

    // Drive a pin change at the current falling edge (no waiting)
    task automatic drive_step(input int dir);
        logic [1:0] p;
        p = pos_of(enc_a, enc_b) + 2'(dir);
        {enc_a, enc_b} = pins_of(p);
    endtask

    task automatic nudge(input int dir);
        @(negedge clk);
        drive_step(dir);
        if (en_model) exp_cnt = exp_cnt + 24'(dir);
        repeat (5) @(negedge clk);
    endtask

    task automatic load_count(input logic [23:0] v);
        send_cmd(8'h01);
        put_data(v[7:0]); put_data(v[15:8]); put_data(v[23:16]);
        send_cmd(8'h08);
        exp_cnt = v;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [23:0] v;
        logic [23:0] old;
        logic [7:0]  b;
        void'($urandom(32'h5EED_0042));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 rdata", 32'(host_rdata), 32'h0);
        check("R1 err", 32'(err_flag), 32'h0);
        fetch(v);
        check("R1 count", 32'(v), 32'h0);

        // R2: motion ignored until both enables are given
        nudge(1); nudge(1); nudge(1);
        fetch(v);
        check("R2 no enable", 32'(v), 32'h0);
        send_cmd(8'h41);
        nudge(1); nudge(-1); nudge(1);
        fetch(v);
        check("R2 only inputs enabled", 32'(v), 32'h0);
        send_cmd(8'h38);
        en_model = 1'b1;

        // R3: x4 counting both ways
        repeat (4) nudge(1);
        fetch(v);
        check("R3 four up", 32'(v), 32'(exp_cnt));
        nudge(-1); nudge(-1);
        fetch(v);
        check("R3 two down", 32'(v), 32'(exp_cnt));

        // R8 clear, R4 wrap down and up
        send_cmd(8'h02);
        exp_cnt = '0;
        fetch(v);
        check("R8 clear", 32'(v), 32'h0);
        nudge(-1);
        fetch(v);
        check("R4 below zero", 32'(v), 32'hFFFFFF);
        nudge(1);
        fetch(v);
        check("R4 back to zero", 32'(v), 32'h0);
        load_count(24'hFFFFFF);
        nudge(1);
        fetch(v);
        check("R4 top wraps", 32'(v), 32'h0);

        // R12: step reaches counter on third edge; R5 same-edge snapshot
        old = exp_cnt;
        @(negedge clk); drive_step(1); exp_cnt = exp_cnt + 24'd1;
        send_cmd(8'h10);
        read_held(v);
        check("R12 second edge old", 32'(v), 32'(old));
        old = exp_cnt;
        @(negedge clk); drive_step(1); exp_cnt = exp_cnt + 24'd1;
        @(negedge clk);
        send_cmd(8'h10);
        read_held(v);
        check("R5 snapshot with step", 32'(v), 32'(old));
        fetch(v);
        check("R5 step kept", 32'(v), 32'(exp_cnt));
        @(negedge clk); drive_step(-1); exp_cnt = exp_cnt - 24'd1;
        repeat (2) @(negedge clk);
        send_cmd(8'h10);
        read_held(v);
        check("R12 third edge new", 32'(v), 32'(exp_cnt));

        // R5: latch frozen while counter runs
        send_cmd(8'h10);
        old = exp_cnt;
        nudge(1); nudge(1); nudge(1);
        read_held(v);
        check("R5 frozen", 32'(v), 32'(old));
        fetch(v);
        check("R5 refreshed", 32'(v), 32'(exp_cnt));

        // R9: preset via data writes and load
        load_count(24'h123456);
        fetch(v);
        check("R9 load", 32'(v), 32'h123456);

        // R6: byte order, auto advance, wrap
        send_cmd(8'h01);
        get_byte(b); check("R6 byte0", 32'(b), 32'h56);
        get_byte(b); check("R6 byte1", 32'(b), 32'h34);
        get_byte(b); check("R6 byte2", 32'(b), 32'h12);
        get_byte(b); check("R6 wrap", 32'(b), 32'h56);
        get_byte(b); check("R6 advance", 32'(b), 32'h34);
        // R7: pointer reset mid-sequence
        send_cmd(8'h01);
        get_byte(b); check("R7 ptr reset", 32'(b), 32'h56);

        // R9: write pointer wraps after the top byte
        send_cmd(8'h01);
        put_data(8'hAA); put_data(8'hBB); put_data(8'hCC); put_data(8'hDD);
        send_cmd(8'h08);
        exp_cnt = 24'hCCBBDD;
        fetch(v);
        check("R9 write wrap", 32'(v), 32'hCCBBDD);

        // R8: clear colliding with a step
        @(negedge clk); drive_step(1);
        @(negedge clk);
        send_cmd(8'h02);
        exp_cnt = '0;
        fetch(v);
        check("R8 clear beats step", 32'(v), 32'h0);
        // R9: load colliding with a step (preset still CCBBDD)
        @(negedge clk); drive_step(-1);
        @(negedge clk);
        send_cmd(8'h08);
        exp_cnt = 24'hCCBBDD;
        fetch(v);
        check("R9 load beats step", 32'(v), 32'hCCBBDD);

        // R11: both phases change in one sample
        @(negedge clk); drive_step(2);
        repeat (5) @(negedge clk);
        check("R11 flag set", 32'(err_flag), 32'h1);
        fetch(v);
        check("R11 count held", 32'(v), 32'(exp_cnt));
        send_cmd(8'h06);
        check("R11 flag cleared", 32'(err_flag), 32'h0);

        // R13: unlisted commands
        send_cmd(8'h55); send_cmd(8'h00); send_cmd(8'hFF); send_cmd(8'h04);
        fetch(v);
        check("R13 count untouched", 32'(v), 32'(exp_cnt));
        check("R13 flag untouched", 32'(err_flag), 32'h0);

        // R10: prescaler 9, sampling every 10 clocks from the command
        send_cmd(8'h01); put_data(8'h09);
        send_cmd(8'h18);
        drive_step(1);
        old = exp_cnt;
        exp_cnt = exp_cnt + 24'd1;
        repeat (7) @(negedge clk);
        send_cmd(8'h10);
        read_held(v);
        check("R10 before sample", 32'(v), 32'(old));
        repeat (12) @(negedge clk);
        fetch(v);
        check("R10 after sample", 32'(v), 32'(exp_cnt));
        send_cmd(8'h18);
        drive_step(1);
        repeat (3) @(negedge clk);
        drive_step(1);
        repeat (15) @(negedge clk);
        check("R10 two changes one sample", 32'(err_flag), 32'h1);
        fetch(v);
        check("R10 no count on merge", 32'(v), 32'(exp_cnt));
        send_cmd(8'h06);
        send_cmd(8'h01); put_data(8'h00);
        send_cmd(8'h18);

        // R3: constrained random walk with random preset loads (R9)
        for (int round = 0; round < 4; round++) begin
            load_count(24'($urandom()));
            for (int k = 0; k < 25; k++) begin
                nudge(($urandom() % 2 == 0) ? 1 : -1);
            end
            fetch(v);
            check("R3 random walk", 32'(v), 32'(exp_cnt));
        end
        check("R11 no flag on walk", 32'(err_flag), 32'h0);

        finish_run();
    end

endmodule